// File: doc/BRIEF.md
# Interrupt Controller Programming Port

This block is the byte-wide, two-address register port of an eight-line interrupt controller. Software sets the controller up with a short initialization sequence. A first word at address 0 with bit 4 set opens it, and two or three further words at address 1 follow. After that, writes to address 0 are operation commands: end-of-interrupt, priority rotation, read selection and poll. Writes to address 1 load the interrupt mask.

The request and in-service registers live in a separate resolver core. The port sees them through the `irr_in` and `isr_in` inputs. It asks the core to drop bits by sending one-cycle clear masks on `isr_clr` and `irr_clr`. It holds the mask, the vector base, the rotating priority offset and the mode flags, and drives all of them as registered outputs. Reads return the request, in-service or mask register, or a poll result. The read data is registered.

Priority is rotating. Rank 0 is the line equal to `prio_off`, rank 1 is the next line up (mod 8), and so on. The line with the lowest rank wins.

Top module: `intc_prog_port`

## Requirements
- R1: A write to address 0 with bit 4 set is the first init word. On the next cycle `imr`, `prio_off`, `vec_base`, `rot_aeoi`, `sfnm`, `aeoi` and `special_mask` are 0. The read select returns to the request register and the poll flag is cleared. `isr_clr` and `irr_clr` are both 8'hFF for exactly that one cycle. The port then waits for the second init word at address 1. After reset these outputs and `rdata` are 0.
- R2: On the first init word, `cfg_err` becomes bit 1 OR bit 3 of that word. Bit 1 requests single mode and bit 3 requests level triggering; both are rejected. A later first init word with both bits clear drops the flag.
- R3: The second init word sets `vec_base` to the written byte AND 8'hF8.
- R4: After the second word, a third word (contents ignored) is expected unless first-word bit 1 was set. A fourth word is expected only if first-word bit 0 was set. Once the sequence ends, the next address-1 write loads the mask.
- R5: In the fourth init word, bit 4 sets `sfnm` and bit 1 sets `aeoi`.
- R6: An address-1 write outside the init sequence loads `imr` with the written byte. An address-1 read returns `imr`.
- R7: An address-0 write with bit 4 clear and bit 3 set is a read/poll command. If bit 1 is set, bit 0 selects the register for address-0 reads: 1 for in-service, 0 for request. If bit 6 is set, bit 5 is loaded into `special_mask`. Bit 2 sets the poll flag.
- R8: Any other address-0 write is a command, with code = bits 7:5. Codes 0 and 4 load `rot_aeoi` with 0 and 1. Code 2 changes nothing.
- R9: Code 1 clears, through `isr_clr`, the in-service line with the lowest rank. If no in-service bit is set, it clears nothing.
- R10: Code 5 behaves as code 1. It also sets `prio_off` to that line + 1 mod 8. If no line is found, `prio_off` is left unchanged.
- R11: Code 3 clears in-service line bits 2:0. Code 7 does the same and also sets `prio_off` to that line + 1 mod 8.
- R12: Code 6 sets `prio_off` to (bits 2:0 + 1) mod 8.
- R13: An address-0 read with the poll flag set is a poll read. The candidate is the unmasked request line with the lowest rank. If that rank is lower than the best in-service rank, the read returns 8'h80 OR line, and the line's bit is set in both `irr_clr` and `isr_clr`. Otherwise the read returns 8'h07. Any address-0 read clears the poll flag.
- R14: `rdata`, the clear masks and every register output change one cycle after the access. A read in the same cycle as a write sees the state before the write. Clear bits from a command and from a poll read in the same cycle are ORed together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 1 | Register address (0 or 1) |
| wdata | input | 8 | Write data |
| irr_in | input | 8 | Request register from the core |
| isr_in | input | 8 | In-service register from the core |
| rdata | output | 8 | Registered read data |
| imr | output | 8 | Interrupt mask |
| vec_base | output | 8 | Vector base (low three bits zero) |
| prio_off | output | 3 | Line that currently holds rank 0 |
| rot_aeoi | output | 1 | Rotate on automatic end-of-interrupt |
| sfnm | output | 1 | Special fully nested mode |
| aeoi | output | 1 | Automatic end-of-interrupt |
| special_mask | output | 1 | Special mask mode flag |
| cfg_err | output | 1 | Rejected init option |
| isr_clr | output | 8 | One-cycle in-service clear mask |
| irr_clr | output | 8 | One-cycle request clear mask |

## Verification
A poll read and an end-of-interrupt command can land in the same cycle, and both drive clear bits toward the core. The bench provokes this by arming poll and then raising a read and a specific end-of-interrupt write together. In the first case an in-service line blocks the poll, so the read must return 8'h07 computed from the pre-write state while the command still clears its line. In the second case both succeed, so `isr_clr` must carry the union of the two lines and `irr_clr` only the polled line. A behavioural model of the port and of the core runs beside the design and is compared on every clock under random traffic.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_W2   = 2'd1,
    SEQ_W3   = 2'd2,
    SEQ_W4   = 2'd3
  } seq_e;

  localparam logic [2:0] OP_ROT_OFF    = 3'd0;
  localparam logic [2:0] OP_EOI_ANY    = 3'd1;
  localparam logic [2:0] OP_NONE       = 3'd2;
  localparam logic [2:0] OP_EOI_LINE   = 3'd3;
  localparam logic [2:0] OP_ROT_ON     = 3'd4;
  localparam logic [2:0] OP_EOI_ANY_R  = 3'd5;
  localparam logic [2:0] OP_SET_PRIO   = 3'd6;
  localparam logic [2:0] OP_EOI_LINE_R = 3'd7;

  localparam logic [7:0] BASE_KEEP   = 8'hF8;
  localparam logic [7:0] POLL_EMPTY  = 8'h07;
  localparam logic [7:0] POLL_HIT    = 8'h80;
endpackage

// File: rtl/intc_rot_pick.sv
module intc_rot_pick #(
  parameter int LINES = 8,
  localparam int LW = $clog2(LINES)
) (
  input  logic [LINES-1:0] vec,
  input  logic [LW-1:0]    off,
  output logic             found,
  output logic [LW-1:0]    line,
  output logic [LW:0]      rank
);
  always_comb begin
    found = 1'b0;
    line  = '0;
    rank  = (LW+1)'(LINES);
    for (int i = LINES-1; i >= 0; i--) begin
      logic [LW-1:0] idx;
      idx = off + LW'(i);
      if (vec[idx]) begin
        found = 1'b1;
        line  = idx;
        rank  = (LW+1)'(i);
      end
    end
  end
endmodule

// File: rtl/intc_init_seq.sv
module intc_init_seq
  import intc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       icw1_wr,
  input  logic       wr1,
  input  logic [7:0] wdata,
  output logic       busy,
  output logic [7:0] vec_base,
  output logic       sfnm,
  output logic       aeoi
);
  seq_e st;
  logic need4, single;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SEQ_IDLE;
      need4    <= 1'b0;
      single   <= 1'b0;
      vec_base <= '0;
      sfnm     <= 1'b0;
      aeoi     <= 1'b0;
    end else if (icw1_wr) begin
      st       <= SEQ_W2;
      need4    <= wdata[0];
      single   <= wdata[1];
      vec_base <= '0;
      sfnm     <= 1'b0;
      aeoi     <= 1'b0;
    end else if (wr1) begin
      case (st)
        SEQ_W2: begin
          vec_base <= wdata & BASE_KEEP;
          if (!single)    st <= SEQ_W3;
          else if (need4) st <= SEQ_W4;
          else            st <= SEQ_IDLE;
        end
        SEQ_W3: st <= need4 ? SEQ_W4 : SEQ_IDLE;
        SEQ_W4: begin
          sfnm <= wdata[4];
          aeoi <= wdata[1];
          st   <= SEQ_IDLE;
        end
        default: ;
      endcase
    end
  end

  assign busy = (st != SEQ_IDLE);

  p_base_load_r3: assert property (@(posedge clk) disable iff (rst)
    (wr1 && st == SEQ_W2) |=> (vec_base == ($past(wdata) & BASE_KEEP)));
  p_word4_modes_r5: assert property (@(posedge clk) disable iff (rst)
    (wr1 && st == SEQ_W4) |=> (sfnm == $past(wdata[4]) && aeoi == $past(wdata[1])));
  p_skip_tail_r4: assert property (@(posedge clk) disable iff (rst)
    (wr1 && st == SEQ_W2 && single && !need4) |=> !busy);
endmodule

// File: rtl/intc_ocw_exec.sv
module intc_ocw_exec
  import intc_pkg::*;
#(
  parameter int LINES = 8,
  localparam int LW = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             icw1_wr,
  input  logic             ocw2_wr,
  input  logic             ocw3_wr,
  input  logic [7:0]       wdata,
  input  logic             poll_rd,
  input  logic             isr_found,
  input  logic [LW-1:0]    isr_line,
  output logic [LW-1:0]    prio_off,
  output logic             rot_aeoi,
  output logic             read_isr,
  output logic             poll_on,
  output logic             special_mask,
  output logic [LINES-1:0] eoi_clr
);
  logic [2:0]    op;
  logic [LW-1:0] arg;

  assign op  = wdata[7:5];
  assign arg = wdata[LW-1:0];

  always_comb begin
    eoi_clr = '0;
    if (ocw2_wr) begin
      case (op)
        OP_EOI_ANY, OP_EOI_ANY_R:
          if (isr_found) eoi_clr = LINES'(1) << isr_line;
        OP_EOI_LINE, OP_EOI_LINE_R:
          eoi_clr = LINES'(1) << arg;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || icw1_wr) begin
      prio_off     <= '0;
      rot_aeoi     <= 1'b0;
      read_isr     <= 1'b0;
      poll_on      <= 1'b0;
      special_mask <= 1'b0;
    end else begin
      if (ocw3_wr && wdata[2]) poll_on <= 1'b1;
      else if (poll_rd)        poll_on <= 1'b0;
      if (ocw3_wr) begin
        if (wdata[1]) read_isr     <= wdata[0];
        if (wdata[6]) special_mask <= wdata[5];
      end
      if (ocw2_wr) begin
        case (op)
          OP_ROT_OFF, OP_ROT_ON: rot_aeoi <= op[2];
          OP_EOI_ANY_R: if (isr_found) prio_off <= isr_line + LW'(1);
          OP_EOI_LINE_R, OP_SET_PRIO: prio_off <= arg + LW'(1);
          default: ;
        endcase
      end
    end
  end

  p_set_prio_r12: assert property (@(posedge clk) disable iff (rst)
    (ocw2_wr && !icw1_wr && op == OP_SET_PRIO) |=> (prio_off == $past(arg) + LW'(1)));
  p_rot_eoi_r10: assert property (@(posedge clk) disable iff (rst)
    (ocw2_wr && !icw1_wr && op == OP_EOI_ANY_R && isr_found) |=> (prio_off == $past(isr_line) + LW'(1)));
  p_rot_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (ocw2_wr && !icw1_wr && (op == OP_ROT_OFF || op == OP_ROT_ON)) |=> (rot_aeoi == $past(op[2])));
endmodule

// File: rtl/intc_prog_port.sv
module intc_prog_port
  import intc_pkg::*;
#(
  parameter int LINES = 8,
  localparam int LW = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             addr,
  input  logic [7:0]       wdata,
  input  logic [LINES-1:0] irr_in,
  input  logic [LINES-1:0] isr_in,
  output logic [7:0]       rdata,
  output logic [LINES-1:0] imr,
  output logic [7:0]       vec_base,
  output logic [LW-1:0]    prio_off,
  output logic             rot_aeoi,
  output logic             sfnm,
  output logic             aeoi,
  output logic             special_mask,
  output logic             cfg_err,
  output logic [LINES-1:0] isr_clr,
  output logic [LINES-1:0] irr_clr
);
  logic wr0, wr1, rd0, icw1_wr, ocw2_wr, ocw3_wr;
  logic busy, read_isr, poll_on;
  logic req_found, isr_found, poll_hit;
  logic [LW-1:0] req_line, isr_line;
  logic [LW:0]   req_rank, isr_rank;
  logic [LINES-1:0] eoi_clr, poll_clr;

  assign wr0     = wr_en && !addr;
  assign wr1     = wr_en && addr;
  assign rd0     = rd_en && !addr;
  assign icw1_wr = wr0 && wdata[4];
  assign ocw3_wr = wr0 && !wdata[4] && wdata[3];
  assign ocw2_wr = wr0 && !wdata[4] && !wdata[3];

  intc_rot_pick #(.LINES(LINES)) u_req_pick (
    .vec(irr_in & ~imr), .off(prio_off),
    .found(req_found), .line(req_line), .rank(req_rank)
  );

  intc_rot_pick #(.LINES(LINES)) u_isr_pick (
    .vec(isr_in), .off(prio_off),
    .found(isr_found), .line(isr_line), .rank(isr_rank)
  );

  intc_init_seq u_seq (
    .clk(clk), .rst(rst), .icw1_wr(icw1_wr), .wr1(wr1), .wdata(wdata),
    .busy(busy), .vec_base(vec_base), .sfnm(sfnm), .aeoi(aeoi)
  );

  intc_ocw_exec #(.LINES(LINES)) u_ocw (
    .clk(clk), .rst(rst), .icw1_wr(icw1_wr), .ocw2_wr(ocw2_wr),
    .ocw3_wr(ocw3_wr), .wdata(wdata), .poll_rd(rd0),
    .isr_found(isr_found), .isr_line(isr_line),
    .prio_off(prio_off), .rot_aeoi(rot_aeoi), .read_isr(read_isr),
    .poll_on(poll_on), .special_mask(special_mask), .eoi_clr(eoi_clr)
  );

  assign poll_hit = req_found && (req_rank < isr_rank);
  assign poll_clr = (rd0 && poll_on && poll_hit) ? (LINES'(1) << req_line) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      imr     <= '0;
      rdata   <= '0;
      cfg_err <= 1'b0;
      isr_clr <= '0;
      irr_clr <= '0;
    end else begin
      isr_clr <= icw1_wr ? '1 : (eoi_clr | poll_clr);
      irr_clr <= icw1_wr ? '1 : poll_clr;
      if (icw1_wr) begin
        imr     <= '0;
        cfg_err <= wdata[1] | wdata[3];
      end else if (wr1 && !busy) begin
        imr <= wdata[LINES-1:0];
      end
      if (rd_en) begin
        if (addr)          rdata <= 8'(imr);
        else if (poll_on)  rdata <= poll_hit ? (POLL_HIT | 8'(req_line)) : POLL_EMPTY;
        else if (read_isr) rdata <= 8'(isr_in);
        else               rdata <= 8'(irr_in);
      end
    end
  end

  p_init_clear_r1: assert property (@(posedge clk) disable iff (rst)
    icw1_wr |=> (imr == '0 && prio_off == '0 && isr_clr == '1 && irr_clr == '1));
  p_reject_r2: assert property (@(posedge clk) disable iff (rst)
    icw1_wr |=> (cfg_err == ($past(wdata[1]) | $past(wdata[3]))));
  p_mask_load_r6: assert property (@(posedge clk) disable iff (rst)
    (wr1 && !busy) |=> (imr == $past(wdata[LINES-1:0])));
  p_poll_form_r13: assert property (@(posedge clk) disable iff (rst)
    (rd0 && poll_on && !icw1_wr) |=>
      ((rdata == POLL_EMPTY && irr_clr == '0) ||
       (rdata[7] && rdata[6:LW] == '0 && $countones(irr_clr) == 1)));
endmodule

// File: tb/sim_intc_prog_port.sv
module sim_intc_prog_port;
  logic       clk = 1'b0;
  logic       rst, wr_en, rd_en, addr;
  logic [7:0] wdata;
  logic [7:0] tb_irr, tb_isr, inj_irr, inj_isr;
  logic [7:0] rdata, imr, vec_base, isr_clr, irr_clr;
  logic [2:0] prio_off;
  logic       rot_aeoi, sfnm, aeoi, special_mask, cfg_err;
  int n_chk = 0, n_err = 0;
  bit cmp_on = 0;

  always #2 clk = ~clk;

  intc_prog_port u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .irr_in(tb_irr), .isr_in(tb_isr), .rdata(rdata),
    .imr(imr), .vec_base(vec_base), .prio_off(prio_off),
    .rot_aeoi(rot_aeoi), .sfnm(sfnm), .aeoi(aeoi),
    .special_mask(special_mask), .cfg_err(cfg_err),
    .isr_clr(isr_clr), .irr_clr(irr_clr)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model of the port and of the core it talks to
  logic [7:0] m_imr, m_base, m_rdata, m_isrclr, m_irrclr;
  int m_off, m_step;
  bit m_rot, m_sfnm, m_aeoi, m_sel, m_poll, m_smm, m_err, m_need4, m_single;

  function automatic int rank_of(input logic [7:0] v, input int off);
    for (int k = 0; k < 8; k++) if (v[(k + off) % 8]) return k;
    return 8;
  endfunction

  always @(posedge clk) begin
    int pr, pi, ln;
    logic [7:0] ec, pc;
    tb_irr <= (tb_irr & ~irr_clr) | inj_irr;
    tb_isr <= (tb_isr & ~isr_clr) | inj_isr;
    if (rst) begin
      m_imr <= 0; m_base <= 0; m_rdata <= 0; m_isrclr <= 0; m_irrclr <= 0;
      m_off <= 0; m_step <= 0; m_rot <= 0; m_sfnm <= 0; m_aeoi <= 0;
      m_sel <= 0; m_poll <= 0; m_smm <= 0; m_err <= 0; m_need4 <= 0; m_single <= 0;
      tb_irr <= 0; tb_isr <= 0;
    end else begin
      ec = 0; pc = 0;
      pr = rank_of(tb_irr & ~m_imr, m_off);
      pi = rank_of(tb_isr, m_off);
      if (rd_en) begin
        if (addr) m_rdata <= m_imr;
        else if (m_poll) begin
          if (pr < pi) begin
            ln = (pr + m_off) % 8;
            m_rdata <= 8'h80 | 8'(ln);
            pc[ln] = 1'b1;
          end else m_rdata <= 8'h07;
        end else m_rdata <= m_sel ? tb_isr : tb_irr;
        if (!addr) m_poll <= 0;
      end
      if (wr_en && !addr && wdata[4]) begin
        m_imr <= 0; m_base <= 0; m_off <= 0; m_rot <= 0; m_sfnm <= 0; m_aeoi <= 0;
        m_sel <= 0; m_poll <= 0; m_smm <= 0;
        m_err <= wdata[1] | wdata[3];
        m_step <= 2; m_need4 <= wdata[0]; m_single <= wdata[1];
        m_isrclr <= 8'hFF; m_irrclr <= 8'hFF;
      end else begin
        if (wr_en && !addr && wdata[3]) begin
          if (wdata[2]) m_poll <= 1;
          if (wdata[1]) m_sel <= wdata[0];
          if (wdata[6]) m_smm <= wdata[5];
        end else if (wr_en && !addr) begin
          case (wdata[7:5])
            0: m_rot <= 0;
            4: m_rot <= 1;
            1, 5: if (pi < 8) begin
              ln = (pi + m_off) % 8;
              ec[ln] = 1'b1;
              if (wdata[7:5] == 5) m_off <= (ln + 1) % 8;
            end
            3, 7: begin
              ec[wdata[2:0]] = 1'b1;
              if (wdata[7:5] == 7) m_off <= (wdata[2:0] + 1) % 8;
            end
            6: m_off <= (wdata[2:0] + 1) % 8;
            default: ;
          endcase
        end else if (wr_en && addr) begin
          if (m_step == 2) begin
            m_base <= wdata & 8'hF8;
            m_step <= !m_single ? 3 : (m_need4 ? 4 : 0);
          end else if (m_step == 3) m_step <= m_need4 ? 4 : 0;
          else if (m_step == 4) begin
            m_sfnm <= wdata[4]; m_aeoi <= wdata[1]; m_step <= 0;
          end else m_imr <= wdata;
        end
        m_isrclr <= ec | pc;
        m_irrclr <= pc;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && cmp_on) begin
      chk("R7 R13 model rdata", rdata, m_rdata);
      chk("R6 model imr", imr, m_imr);
      chk("R3 model vec_base", vec_base, m_base);
      chk("R12 model prio_off", 8'(prio_off), 8'(m_off));
      chk("R5 R8 model modes", {4'd0, rot_aeoi, sfnm, aeoi, special_mask},
          {4'd0, m_rot, m_sfnm, m_aeoi, m_smm});
      chk("R2 model cfg_err", 8'(cfg_err), 8'(m_err));
      chk("R9 R11 model isr_clr", isr_clr, m_isrclr);
      chk("R13 model irr_clr", irr_clr, m_irrclr);
    end
  end

  task automatic acc(input logic a, input logic [7:0] d, input bit w, input bit r);
    addr = a; wdata = d; wr_en = w; rd_en = r;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask
  task automatic wr(input logic a, input logic [7:0] d); acc(a, d, 1, 0); endtask
  task automatic rd(input logic a); acc(a, 8'h00, 0, 1); endtask
  task automatic inj(input logic [7:0] ir, input logic [7:0] is);
    inj_irr = ir; inj_isr = is;
    @(negedge clk);
    inj_irr = 0; inj_isr = 0;
  endtask

  task automatic wrap_up();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    wrap_up();
  end

  initial begin
    rst = 1; wr_en = 0; rd_en = 0; addr = 0; wdata = 0; inj_irr = 0; inj_isr = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset imr", imr, 8'h00);
    chk("R1 reset rdata", rdata, 8'h00);
    chk("R1 reset prio_off", 8'(prio_off), 8'h00);
    cmp_on = 1;

    wr(0, 8'h11);
    chk("R1 init isr_clr", isr_clr, 8'hFF);
    chk("R1 init irr_clr", irr_clr, 8'hFF);
    wr(1, 8'h4D); chk("R3 base", vec_base, 8'h48);
    wr(1, 8'h04); wr(1, 8'h12);
    chk("R5 sfnm", 8'(sfnm), 8'h01);
    chk("R5 aeoi", 8'(aeoi), 8'h01);
    wr(1, 8'hA5); chk("R6 mask", imr, 8'hA5);
    rd(1); chk("R6 mask read", rdata, 8'hA5);

    wr(0, 8'h13); chk("R2 single rejected", 8'(cfg_err), 8'h01);
    wr(1, 8'h20); wr(1, 8'h00); wr(1, 8'h5A);
    chk("R4 third word skipped", imr, 8'h5A);
    wr(0, 8'h18); chk("R2 level rejected", 8'(cfg_err), 8'h01);
    wr(0, 8'h10); chk("R2 flag dropped", 8'(cfg_err), 8'h00);
    wr(1, 8'h00); wr(1, 8'h00); wr(1, 8'h3C);
    chk("R4 no fourth word", imr, 8'h3C);

    wr(0, 8'h80); chk("R8 rotate on", 8'(rot_aeoi), 8'h01);
    wr(0, 8'h40); chk("R8 code 2 inert", 8'(rot_aeoi), 8'h01);
    chk("R8 code 2 mask kept", imr, 8'h3C);
    wr(0, 8'h00); chk("R8 rotate off", 8'(rot_aeoi), 8'h00);

    wr(0, 8'hC3); chk("R12 set priority", 8'(prio_off), 8'h04);
    inj(8'h00, 8'h21);
    wr(0, 8'hA0);
    chk("R9 lowest rank cleared", isr_clr, 8'h20);
    chk("R10 rotation offset", 8'(prio_off), 8'h06);
    @(negedge clk);
    wr(0, 8'h62); chk("R11 specific line", isr_clr, 8'h04);
    wr(0, 8'hE1); chk("R11 specific rotate clr", isr_clr, 8'h02);
    chk("R11 specific rotate off", 8'(prio_off), 8'h02);
    @(negedge clk);
    wr(0, 8'h20); chk("R9 clears remaining line", isr_clr, 8'h01);
    @(negedge clk);
    wr(0, 8'h20); chk("R9 nothing in service", isr_clr, 8'h00);

    inj(8'h90, 8'h01);
    wr(0, 8'h0B); rd(0); chk("R7 read in-service", rdata, 8'h01);
    wr(0, 8'h0A); rd(0); chk("R7 read request", rdata, 8'h90);
    wr(0, 8'h09); rd(0); chk("R7 select needs bit 1", rdata, 8'h90);
    wr(0, 8'h68); chk("R7 special mask", 8'(special_mask), 8'h01);

    wr(0, 8'h10); wr(1, 8'h08); wr(1, 8'h00);
    inj(8'h48, 8'h00);
    wr(0, 8'h0C); rd(0);
    chk("R13 poll result", rdata, 8'h83);
    chk("R13 poll irr_clr", irr_clr, 8'h08);
    chk("R13 poll isr_clr", isr_clr, 8'h08);
    @(negedge clk);
    rd(0); chk("R13 poll flag self-clears", rdata, 8'h40);
    inj(8'h00, 8'h02);
    wr(0, 8'h0C); rd(0);
    chk("R13 blocked by in-service", rdata, 8'h07);
    chk("R13 blocked no clear", irr_clr, 8'h00);

    wr(0, 8'h0C); acc(0, 8'h61, 1, 1);
    chk("R14 read sees pre-write", rdata, 8'h07);
    chk("R14 command clear alone", isr_clr, 8'h02);
    chk("R14 no request clear", irr_clr, 8'h00);
    @(negedge clk);
    wr(0, 8'h0C); acc(0, 8'h65, 1, 1);
    chk("R14 poll hit with command", rdata, 8'h86);
    chk("R14 merged isr_clr", isr_clr, 8'h60);
    chk("R14 poll irr_clr", irr_clr, 8'h40);
    @(negedge clk);
    inj(8'h50, 8'h00);
    wr(1, 8'h10); wr(0, 8'h0C); rd(0);
    chk("R13 masked line skipped", rdata, 8'h86);

    for (int c = 0; c < 2000; c++) begin
      logic [7:0] d;
      d = 8'($urandom);
      if (d[4] && ($urandom % 8 != 0)) d[4] = 1'b0;
      inj_irr = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
      inj_isr = ($urandom % 6 == 0) ? 8'($urandom) : 8'h00;
      acc(1'($urandom), d, ($urandom % 3 == 0), ($urandom % 3 == 0));
      inj_irr = 0; inj_isr = 0;
    end
    repeat (2) @(negedge clk);
    wrap_up();
  end
endmodule